// File: doc/BRIEF.md
# Synchronous Channel Rendezvous Unit

This unit joins two processes over a numbered channel and moves one message between them without any intermediate buffering. Each process presents a single operation carrying a direction (send or receive), a channel number, a word count, a buffer address in shared memory and a requester tag. The first operation to reach a channel is parked in that channel's waiting slot, and its requester stays stalled. When an operation of the opposite direction later reaches the same channel, the slot is released. A copy engine then moves words from the sending buffer to the receiving buffer through a memory port that has one read lane and one write lane. Both requesters are released together.

Channels are fixed numbers chosen by software. Any channel that has no physical link behind it is served here as a purely logical one. The operation interface is a valid/ready pair. Ready drops while a copy runs.

Top module: `chan_rendezvous`

## Requirements
- R1: After reset, `req_ready` is 1, and `done_valid`, `req_err`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: An operation that finds its channel's slot empty is parked. It produces no `done_valid`, no `req_err` and no memory access.
- R3: When a partner of the opposite direction (`req_dir` 0 = send, 1 = receive) arrives, word k of the copy is read from sender address + k. In the following cycle it is written to receiver address + k, carrying the data read.
- R4: The copy length is the sender's length when the receiver's length is at least as large. Otherwise it is the receiver's length, and `done_trunc` is raised with the done pulse. Words of the receive buffer past the copy length are left untouched.
- R5: `done_valid` is a one-cycle pulse that carries both requester tags. It is visible in the cycle right after the last write, which is N+2 cycles after the accepting edge for a copy of N>0 words.
- R6: A second operation of the same direction on a channel that is already waiting is dropped. `req_err` pulses in the next cycle, and the parked operation is kept for its real partner.
- R7: A rendezvous with a copy length of zero gives `done_valid` in the cycle right after acceptance, with no memory access.
- R8: `req_ready` is 0 from the accepting edge of a matching non-zero copy until the done pulse. The memory port is idle whenever `req_ready` is 1.
- R9: Channels are independent. A match on one channel neither completes nor clears a slot parked on another channel.
- R10: The outcome does not depend on which side arrives first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation present |
| req_ready | output | 1 | Unit can accept an operation |
| req_dir | input | 1 | 0 = send, 1 = receive |
| req_ch | input | CH_W | Channel number |
| req_len | input | LEN_W | Message length in words |
| req_addr | input | ADDR_W | Buffer base address |
| req_id | input | ID_W | Requester tag |
| req_err | output | 1 | Same-direction collision, operation dropped |
| done_valid | output | 1 | Rendezvous complete, both sides released |
| done_snd_id | output | ID_W | Tag of the sender |
| done_rcv_id | output | ID_W | Tag of the receiver |
| done_trunc | output | 1 | Receiver buffer shorter than message |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |

## Verification
The assertions assume two things about the environment. Operations are offered only while `req_ready` is high. Memory returns read data exactly one cycle after a read strobe. The stimulus follows both rules: every operation waits for ready before it is driven, and the bench memory is a registered array. Source and destination regions never overlap, so that a read and a write to the same word cannot collide within one cycle. Under those conditions the memory port is idle whenever the unit is ready, every write follows a read, and the done pulse lands right after the final write.

// File: rtl/rdv_pkg.sv
// Shared definitions for the channel rendezvous unit.
// Assumes: the direction encoding below is fixed at the port (0 send, 1 receive).
package rdv_pkg;
    typedef enum logic {DIR_SEND = 1'b0, DIR_RECV = 1'b1} dir_e;
endpackage

// File: rtl/rdv_slot_bank.sv
// Per-channel waiting slots. Each slot holds one parked operation.
// Assumes: set and clear are never raised together for the same channel.
module rdv_slot_bank #(
    parameter int NUM_CH = 4,
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 8,
    parameter int ID_W   = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [CH_W-1:0]   sel_ch,
    input  rdv_pkg::dir_e     in_dir,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [ID_W-1:0]   in_id,
    output logic              hit,
    output rdv_pkg::dir_e     hit_dir,
    output logic [LEN_W-1:0]  hit_len,
    output logic [ADDR_W-1:0] hit_addr,
    output logic [ID_W-1:0]   hit_id
);
    logic                vld_q  [NUM_CH];
    rdv_pkg::dir_e       dir_q  [NUM_CH];
    logic [LEN_W-1:0]    len_q  [NUM_CH];
    logic [ADDR_W-1:0]   addr_q [NUM_CH];
    logic [ID_W-1:0]     id_q   [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        // Park or release this channel's waiting operation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[c]  <= 1'b0;
                dir_q[c]  <= rdv_pkg::DIR_SEND;
                len_q[c]  <= '0;
                addr_q[c] <= '0;
                id_q[c]   <= '0;
            end else if (sel_ch == CH_W'(c)) begin
                if (set_en) begin
                    vld_q[c]  <= 1'b1;
                    dir_q[c]  <= in_dir;
                    len_q[c]  <= in_len;
                    addr_q[c] <= in_addr;
                    id_q[c]   <= in_id;
                end else if (clr_en) begin
                    vld_q[c]  <= 1'b0;
                end
            end
        end
    end

    // Present the selected channel's slot.
    always_comb begin
        hit      = vld_q[sel_ch];
        hit_dir  = dir_q[sel_ch];
        hit_len  = len_q[sel_ch];
        hit_addr = addr_q[sel_ch];
        hit_id   = id_q[sel_ch];
    end
endmodule

// File: rtl/rdv_copy_engine.sv
// Word copier: one read issued per cycle and the matching write one cycle later.
// Assumes: memory read data arrives one cycle after the read strobe; start only while idle.
module rdv_copy_engine #(
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [ADDR_W-1:0] start_src,
    input  logic [ADDR_W-1:0] start_dst,
    input  logic [ID_W-1:0]   start_snd_id,
    input  logic [ID_W-1:0]   start_rcv_id,
    input  logic              start_trunc,
    output logic              busy,
    output logic              done,
    output logic [ID_W-1:0]   done_snd_id,
    output logic [ID_W-1:0]   done_rcv_id,
    output logic              done_trunc,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [LEN_W-1:0]  len_q, rd_idx_q, wr_idx_q;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic              wr_pend_q;
    logic              last_wr;

    // Memory lane outputs derived from the copy cursors.
    always_comb begin
        rd_en   = busy && (rd_idx_q != len_q);
        rd_addr = src_q + ADDR_W'(rd_idx_q);
        wr_en   = wr_pend_q;
        wr_addr = dst_q + ADDR_W'(wr_idx_q);
        wr_data = rd_data;
        last_wr = wr_pend_q && (wr_idx_q == len_q - LEN_W'(1));
    end

    // Copy sequencing and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            done        <= 1'b0;
            len_q       <= '0;
            rd_idx_q    <= '0;
            wr_idx_q    <= '0;
            wr_pend_q   <= 1'b0;
            src_q       <= '0;
            dst_q       <= '0;
            done_snd_id <= '0;
            done_rcv_id <= '0;
            done_trunc  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                len_q       <= start_len;
                src_q       <= start_src;
                dst_q       <= start_dst;
                rd_idx_q    <= '0;
                wr_pend_q   <= 1'b0;
                done_snd_id <= start_snd_id;
                done_rcv_id <= start_rcv_id;
                done_trunc  <= start_trunc;
                if (start_len == '0) done <= 1'b1;
                else                 busy <= 1'b1;
            end else if (busy) begin
                if (rd_en) rd_idx_q <= rd_idx_q + LEN_W'(1);
                wr_pend_q <= rd_en;
                wr_idx_q  <= rd_idx_q;
                if (last_wr) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/chan_rendezvous.sv
// Synchronous rendezvous over numbered channels: park first arriver, copy on match.
// Assumes: operations are offered only while req_ready is high.
module chan_rendezvous #(
    parameter int NUM_CH = 4,
    parameter int LEN_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int ID_W   = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_dir,
    input  logic [CH_W-1:0]   req_ch,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ID_W-1:0]   req_id,
    output logic              req_err,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_snd_id,
    output logic [ID_W-1:0]   done_rcv_id,
    output logic              done_trunc,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    import rdv_pkg::*;

    dir_e              in_dir, hit_dir;
    logic              hit, accept, park, pair, clash, busy;
    logic [LEN_W-1:0]  hit_len, s_len, r_len, cp_len;
    logic [ADDR_W-1:0] hit_addr, s_addr, r_addr;
    logic [ID_W-1:0]   hit_id, s_id, r_id;
    logic              trunc;

    assign in_dir = dir_e'(req_dir);

    rdv_slot_bank #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .set_en(park), .clr_en(pair), .sel_ch(req_ch),
        .in_dir(in_dir), .in_len(req_len), .in_addr(req_addr), .in_id(req_id),
        .hit(hit), .hit_dir(hit_dir), .hit_len(hit_len), .hit_addr(hit_addr), .hit_id(hit_id)
    );

    // Classify the incoming operation and pick sender/receiver roles.
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
        park      = accept && !hit;
        clash     = accept && hit && (hit_dir == in_dir);
        pair      = accept && hit && (hit_dir != in_dir);
        if (in_dir == DIR_SEND) begin
            s_len = req_len;  s_addr = req_addr;  s_id = req_id;
            r_len = hit_len;  r_addr = hit_addr;  r_id = hit_id;
        end else begin
            s_len = hit_len;  s_addr = hit_addr;  s_id = hit_id;
            r_len = req_len;  r_addr = req_addr;  r_id = req_id;
        end
        trunc  = r_len < s_len;
        cp_len = trunc ? r_len : s_len;
    end

    // Collision flag, one cycle after the rejected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) req_err <= 1'b0;
        else        req_err <= clash;
    end

    rdv_copy_engine #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_copy (
        .clk(clk), .rst_n(rst_n), .start(pair), .start_len(cp_len),
        .start_src(s_addr), .start_dst(r_addr), .start_snd_id(s_id), .start_rcv_id(r_id),
        .start_trunc(trunc), .busy(busy), .done(done_valid), .done_snd_id(done_snd_id),
        .done_rcv_id(done_rcv_id), .done_trunc(done_trunc),
        .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
        .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data)
    );
endmodule

// File: rtl/rdv_checker.sv
// Protocol checker for chan_rendezvous, attached by bind.
// Assumes: environment offers operations only while ready; memory has one-cycle read latency.
module rdv_checker (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic req_err,
    input logic done_valid,
    input logic mem_rd_en,
    input logic mem_wr_en
);
    // R8: memory port is idle while the unit is ready.
    a_r8_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_en && !mem_wr_en));

    // R3: every write is preceded by a read in the previous cycle.
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));

    // R5: the final write (no read alongside) is followed by the done pulse.
    a_r5_done_after_last_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !mem_rd_en) |=> done_valid);

    // R5: both sides are released with the unit ready again.
    a_r5_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> req_ready);

    // R6: a rejected operation never completes a rendezvous.
    a_r6_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_err && done_valid));
endmodule

bind chan_rendezvous rdv_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_err(req_err),
    .done_valid(done_valid), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en)
);

// File: tb/sim_chan_rendezvous.sv
`timescale 1ns/1ps
module sim_chan_rendezvous;
    localparam int NUM_CH = 4, LEN_W = 8, ADDR_W = 8, DATA_W = 16, ID_W = 4;
    localparam int CH_W = $clog2(NUM_CH);
    localparam int DEPTH = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_dir = 1'b0;
    logic [CH_W-1:0] req_ch = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ID_W-1:0] req_id = '0;
    logic req_ready, req_err, done_valid, done_trunc;
    logic [ID_W-1:0] done_snd_id, done_rcv_id;
    logic mem_rd_en, mem_wr_en;
    logic [ADDR_W-1:0] mem_rd_addr, mem_wr_addr;
    logic [DATA_W-1:0] mem_rd_data, mem_wr_data;

    logic [DATA_W-1:0] mem [DEPTH];
    int n_chk = 0, n_fail = 0, n_acc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    chan_rendezvous u0 (.*);

    // Bench memory: registered read, one-cycle latency; access counter.
    always_ff @(posedge clk) begin
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_rd_en || mem_wr_en) n_acc <= n_acc + 1;
    end

    function automatic logic [DATA_W-1:0] pat(int a);
        return DATA_W'((a * 16'h0101) ^ 16'h5A3C);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one operation; returns at the first negedge after it is accepted.
    task automatic issue(bit dir, int ch, int len, int addr, int id);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_dir = dir; req_ch = CH_W'(ch);
        req_len = LEN_W'(len); req_addr = ADDR_W'(addr); req_id = ID_W'(id);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Count cycles until done; k=1 means done already visible now.
    task automatic wait_done(output int k, output bit ready_low);
        k = 1; ready_low = 1;
        while (!done_valid && k < 300) begin
            if (req_ready) ready_low = 0;
            @(negedge clk);
            k++;
        end
    endtask

    // {ch, snd_len, rcv_len, snd_addr, rcv_addr, rcv_first}
    localparam logic [39:0] VEC [6] = '{
        {4'd0, 8'd4, 8'd4, 8'h10, 8'h80, 4'd0},
        {4'd1, 8'd3, 8'd3, 8'h20, 8'h90, 4'd1},
        {4'd2, 8'd6, 8'd4, 8'h30, 8'hA0, 4'd0},
        {4'd3, 8'd2, 8'd5, 8'h40, 8'hB0, 4'd1},
        {4'd1, 8'd1, 8'd1, 8'h50, 8'hC0, 4'd0},
        {4'd0, 8'd0, 8'd3, 8'h60, 8'hD0, 4'd1}
    };

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = pat(a);
        mem_rd_data = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(!done_valid && !req_err, "R1 flags", int'(done_valid | req_err), 0);
        chk(!mem_rd_en && !mem_wr_en, "R1 mem idle", int'(mem_rd_en | mem_wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            int ch, sl, rl, sa, ra, cl, k, acc0;
            bit rf, rlow;
            {ch, sl, rl, sa, ra, rf} = {28'd0, VEC[i][39:36], 24'd0, VEC[i][35:28],
                                        24'd0, VEC[i][27:20], 24'd0, VEC[i][19:12],
                                        24'd0, VEC[i][11:4], VEC[i][0]};
            cl = (rl < sl) ? rl : sl;
            acc0 = n_acc;
            // R2 / R10: first arriver parks, side order varies by vector
            if (rf) issue(1'b1, ch, rl, ra, 2*i+1);
            else    issue(1'b0, ch, sl, sa, 2*i);
            chk(!done_valid && !req_err, "R2 parked no done", int'(done_valid), 0);
            chk(n_acc == acc0, "R2 parked no access", n_acc - acc0, 0);
            if (rf) issue(1'b0, ch, sl, sa, 2*i);
            else    issue(1'b1, ch, rl, ra, 2*i+1);
            wait_done(k, rlow);
            // R5 / R7: done timing
            chk(k == ((cl == 0) ? 1 : cl + 2), "R5 done latency", k, (cl == 0) ? 1 : cl + 2);
            if (cl > 0) chk(rlow, "R8 ready low during copy", int'(rlow), 1);
            else        chk(n_acc == acc0, "R7 zero length no access", n_acc - acc0, 0);
            chk(done_snd_id == ID_W'(2*i) && done_rcv_id == ID_W'(2*i+1), "R10 ids",
                int'({done_snd_id, done_rcv_id}), int'({ID_W'(2*i), ID_W'(2*i+1)}));
            chk(done_trunc == (rl < sl), "R4 trunc flag", int'(done_trunc), int'(rl < sl));
            @(negedge clk);
            chk(!done_valid, "R5 done one cycle", int'(done_valid), 0);
            for (int w = 0; w < cl; w++)
                chk(mem[ra+w] == pat(sa+w), "R3 copied word", int'(mem[ra+w]), int'(pat(sa+w)));
            chk(mem[ra+cl] == pat(ra+cl), "R4 beyond length untouched",
                int'(mem[ra+cl]), int'(pat(ra+cl)));
        end

        // R6: same-direction collision is dropped, original kept
        begin
            int k; bit rlow;
            issue(1'b0, 2, 2, 8'h70, 4'd3);
            issue(1'b0, 2, 2, 8'h78, 4'd9);
            chk(req_err == 1'b1, "R6 err pulse", int'(req_err), 1);
            @(negedge clk);
            chk(req_err == 1'b0, "R6 err single cycle", int'(req_err), 0);
            issue(1'b1, 2, 2, 8'hE0, 4'd5);
            wait_done(k, rlow);
            chk(done_snd_id == 4'd3, "R6 original sender kept", int'(done_snd_id), 3);
            @(negedge clk);
            chk(mem[8'hE0] == pat(8'h70), "R6 data from original", int'(mem[8'hE0]), int'(pat(8'h70)));
        end

        // R9: channels independent
        begin
            int k; bit rlow;
            issue(1'b0, 0, 1, 8'h12, 4'd1);
            issue(1'b0, 1, 1, 8'h22, 4'd2);
            issue(1'b1, 1, 1, 8'hE8, 4'd6);
            wait_done(k, rlow);
            chk(done_snd_id == 4'd2 && done_rcv_id == 4'd6, "R9 ch1 match",
                int'(done_snd_id), 2);
            issue(1'b1, 0, 1, 8'hEC, 4'd7);
            wait_done(k, rlow);
            chk(done_snd_id == 4'd1 && done_rcv_id == 4'd7, "R9 ch0 still parked",
                int'(done_snd_id), 1);
            @(negedge clk);
            chk(mem[8'hEC] == pat(8'h12), "R9 ch0 data", int'(mem[8'hEC]), int'(pat(8'h12)));
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule